// File: doc/BRIEF.md
# Streaming serial-flash read sequencer

This block runs a read session against a serial flash and deposits the result, one 32-bit word at a time, into a small read FIFO. Software first programs the phase shape: the opcode, how many lanes each of the command, address and data phases uses, how many dummy bits follow the address, and whether the address is three or four bytes wide. It then makes that shape live with a separate commit write. A session takes a start address and a word count and is launched by a control write. The engine then drives chip select and the serial clock, shifts out the command and address, idles through the dummy clocks and shifts the data in. Each completed word is packed with the first flash byte in the lowest byte lane.

Software drains the FIFO by reading the data register and polls a status register for busy and empty. When the FIFO fills, the serial clock parks low until a word is popped. When four-byte addressing is used, the top address byte comes from its own register and stays fixed for the session. A session therefore never leaves its 16 MB window: it ends early at the window edge. Two read-only registers report how many words have been fetched and the next flash address.

The register bus is a single-cycle word-addressed port. Writes take effect on the clock edge. Read data is combinational from the address.

Top module: `flash_raf_seq`

## Requirements
- R1: After reset the status register (address 7) reads 2 (bit 0 busy = 0, bit 1 FIFO empty = 1), cs_n is 1, sck is 0 and the word-count register (address 9) reads 0.
- R2: The lane register (address 0) holds log2 of the lane count per phase: data in bits [1:0], address in bits [17:16] and command in bits [25:24]. Code 0 means one lane, code 1 means two lanes and code 2 means four lanes. In one-lane mode output is on io_out[0] and input is sampled from io_in[1]. Two lanes use bits [1:0] and four lanes use bits [3:0]. Bits go most significant first, and the higher-order bit of a beat goes on the higher lane.
- R3: The phase register (address 1) holds the dummy bit count in bits [7:0]. The number of dummy clocks, with no lanes driven, is that count shifted right by the data lane code.
- R4: In three-byte mode the address phase sends the low 24 bits of the start register (address 4). When bit 16 of the phase register is set, the address phase sends 32 bits: the upper-address byte first, taken from bits [31:24] of address 3, then those same low 24 bits.
- R5: Writes to the lane, phase, opcode (address 2, bits [7:0]) and upper-address registers do not change the sequence sent on the pins until a 1 is written to bit 0 of the commit register (address 11).
- R6: Writing 1 to bit 0 of the control register (address 6) starts a session that reads the number of words held in address 5. The write has no effect while a session is busy or when the count is 0.
- R7: Reading address 8 pops one word, with the first flash byte in bits [7:0] and the fourth in bits [31:24]. A read of address 8 while the FIFO is empty returns 0 and pops nothing.
- R8: A session stops after the word at the last 4-byte slot of its 16 MB window, even if fewer words than requested have been fetched. The low 24 bits of the current address then wrap to 0.
- R9: While the FIFO is full at the start of a word, sck stays low and cs_n stays asserted. Fetching resumes after a pop.
- R10: Busy clears, and cs_n returns high, in the same cycle as the last word of the session is written to the FIFO.
- R11: The word-count register (address 9) reports the words fetched in the current or last session. The current-address register (address 10) reports the next flash address, as the upper byte (or 0 in three-byte mode) above the low 24 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops on the data address) |
| bus_addr | input | AW | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| sck | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Chip select, active low |
| io_out | output | 4 | Lane output values |
| io_oe | output | 4 | Lane output enables |
| io_in | input | 4 | Lane input values |

## Verification
A behavioural flash model in the bench decodes the opcode and address from the pins using the committed lane widths. It returns an address-derived byte stream, so a design that gets the lane order, the dummy clock count or the byte packing wrong shows up as word mismatches or as a wrong captured opcode or address. The bench changes the phase shape without committing it and checks that the old opcode still goes out; a design that applied writes directly would send the new one. A session started 8 bytes below a window edge must stop after two words and wrap the address, where a design without the window limit would run on into the next window. A session longer than the FIFO, left undrained, must freeze its clock and ignore a second start. A design that overflowed, kept clocking or restarted would lose or duplicate words once the FIFO is drained.

// File: rtl/flash_raf_seq.sv
module flash_raf_seq #(
  parameter int DEPTH = 4,
  parameter int AW    = 4,
  parameter int CW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          sck,
  output logic          cs_n,
  output logic [3:0]    io_out,
  output logic [3:0]    io_oe,
  input  logic [3:0]    io_in
);
  localparam int PW = $clog2(DEPTH);
  localparam logic [AW-1:0] A_LANE = 0, A_PHASE = 1, A_OP = 2, A_UP = 3, A_START = 4,
                            A_COUNT = 5, A_CTRL = 6, A_STAT = 7, A_DATA = 8,
                            A_WC = 9, A_CUR = 10, A_COMMIT = 11;

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_ADDR, S_DUM, S_DATA} state_t;
  state_t state;

  logic [1:0]  sh_lc, sh_la, sh_ld, act_lc, act_la, act_ld;
  logic [7:0]  sh_dummy, act_dummy, sh_op, act_op, sh_up, act_up;
  logic        sh_a4, act_a4;
  logic [23:0] start_lo, cur;
  logic [CW-1:0] req_count, wdone, wtotal;

  logic        ph;
  logic [7:0]  beats;
  logic [31:0] sr, raw;

  logic [31:0]   mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [PW:0]   cnt;

  wire [1:0] lc = (act_lc == 2'd3) ? 2'd2 : act_lc;
  wire [1:0] la = (act_la == 2'd3) ? 2'd2 : act_la;
  wire [1:0] ld = (act_ld == 2'd3) ? 2'd2 : act_ld;
  wire [1:0] lw_cur = (state == S_CMD) ? lc : (state == S_ADDR) ? la : ld;
  wire [7:0] dbeats = 8'd32 >> ld;
  wire [7:0] dumb   = act_dummy >> ld;
  wire       busy   = (state != S_IDLE);
  wire       empty  = (cnt == '0);
  wire       full   = (cnt == (PW+1)'(DEPTH));
  wire       stall  = (state == S_DATA) && !ph && (beats == dbeats) && full;
  wire       push   = (state == S_DATA) && ph && (beats == 8'd1);
  wire       pop    = bus_rd && (bus_addr == A_DATA) && !empty;
  wire       start_req = bus_wr && (bus_addr == A_CTRL) && bus_wdata[0];
  wire       last_word = (CW'(wdone + CW'(1)) == wtotal) || (&cur[23:2]);
  wire [31:0] word  = {raw[7:0], raw[15:8], raw[23:16], raw[31:24]};
  wire [3:0]  samp  = (ld == 2'd0) ? {3'b0, io_in[1]} :
                      (ld == 2'd1) ? {2'b0, io_in[1:0]} : io_in;
  wire        drive = (state == S_CMD) || (state == S_ADDR);

  assign io_oe  = !drive ? 4'b0000 : (lw_cur == 2'd0) ? 4'b0001 :
                  (lw_cur == 2'd1) ? 4'b0011 : 4'b1111;
  assign io_out = !drive ? 4'b0000 : (lw_cur == 2'd0) ? {3'b0, sr[31]} :
                  (lw_cur == 2'd1) ? {2'b0, sr[31:30]} : sr[31:28];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {sh_lc, sh_la, sh_ld, act_lc, act_la, act_ld} <= '0;
      {sh_dummy, act_dummy, sh_op, act_op, sh_up, act_up} <= '0;
      {sh_a4, act_a4} <= '0;
      start_lo <= '0;
      req_count <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_LANE:  begin sh_ld <= bus_wdata[1:0]; sh_la <= bus_wdata[17:16]; sh_lc <= bus_wdata[25:24]; end
        A_PHASE: begin sh_dummy <= bus_wdata[7:0]; sh_a4 <= bus_wdata[16]; end
        A_OP:    sh_op <= bus_wdata[7:0];
        A_UP:    sh_up <= bus_wdata[31:24];
        A_START: start_lo <= bus_wdata[23:0];
        A_COUNT: req_count <= bus_wdata[CW-1:0];
        A_COMMIT: if (bus_wdata[0] && !busy) begin
          {act_lc, act_la, act_ld} <= {sh_lc, sh_la, sh_ld};
          {act_dummy, act_op, act_up, act_a4} <= {sh_dummy, sh_op, sh_up, sh_a4};
        end
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE; cs_n <= 1'b1; sck <= 1'b0; ph <= 1'b0;
      beats <= '0; sr <= '0; raw <= '0; wdone <= '0; wtotal <= '0; cur <= '0;
    end else if (state == S_IDLE) begin
      if (start_req && req_count != '0) begin
        state <= S_CMD; cs_n <= 1'b0; ph <= 1'b0; sck <= 1'b0;
        beats <= 8'd8 >> lc; sr <= {act_op, 24'h0};
        wdone <= '0; wtotal <= req_count; cur <= start_lo;
      end
    end else if (!stall) begin
      if (!ph) begin
        sck <= 1'b1; ph <= 1'b1;
        if (state == S_DATA) raw <= (raw << (6'd1 << ld)) | {28'h0, samp};
      end else begin
        sck <= 1'b0; ph <= 1'b0;
        if (beats != 8'd1) begin
          beats <= beats - 8'd1;
          sr <= sr << (6'd1 << lw_cur);
        end else begin
          case (state)
            S_CMD: begin
              state <= S_ADDR;
              beats <= (act_a4 ? 8'd32 : 8'd24) >> la;
              sr <= act_a4 ? {act_up, cur} : {cur, 8'h0};
            end
            S_ADDR: begin
              state <= (dumb != 8'd0) ? S_DUM : S_DATA;
              beats <= (dumb != 8'd0) ? dumb : dbeats;
            end
            S_DUM: begin state <= S_DATA; beats <= dbeats; end
            default: begin
              wdone <= CW'(wdone + CW'(1));
              cur <= cur + 24'd4;
              beats <= dbeats;
              if (last_word) begin state <= S_IDLE; cs_n <= 1'b1; end
            end
          endcase
        end
      end
    end

  always_ff @(posedge clk) if (push) mem[wp] <= word;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (push) wp <= wp + PW'(1);
      if (pop)  rp <= rp + PW'(1);
      cnt <= cnt + {{PW{1'b0}}, push} - {{PW{1'b0}}, pop};
    end

  always_comb
    case (bus_addr)
      A_LANE:  bus_rdata = {6'b0, sh_lc, 6'b0, sh_la, 14'b0, sh_ld};
      A_PHASE: bus_rdata = {15'b0, sh_a4, 8'b0, sh_dummy};
      A_OP:    bus_rdata = {24'b0, sh_op};
      A_UP:    bus_rdata = {sh_up, 24'b0};
      A_START: bus_rdata = {8'b0, start_lo};
      A_COUNT: bus_rdata = {{(32-CW){1'b0}}, req_count};
      A_STAT:  bus_rdata = {30'b0, empty, busy};
      A_DATA:  bus_rdata = empty ? 32'h0 : mem[rp];
      A_WC:    bus_rdata = {{(32-CW){1'b0}}, wdone};
      A_CUR:   bus_rdata = {act_a4 ? act_up : 8'h00, cur};
      default: bus_rdata = 32'h0;
    endcase

  p_cs_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> cs_n);
  p_sck_park_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt < (PW+1)'(DEPTH)));
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (!sck && !cs_n && $stable(wdone)));
  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (wdone < wtotal));
  p_pop_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !push) |=> empty);
endmodule

// File: tb/tb_flash_raf_seq.sv
module tb_flash_raf_seq;
  logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0;
  logic [3:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic sck, cs_n;
  logic [3:0] io_out, io_oe, fl_io;

  always #4 clk = ~clk;

  flash_raf_seq dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .sck(sck), .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe), .io_in(fl_io));

  int n_chk = 0, n_bad = 0;
  int m_lc = 0, m_la = 0, m_ld = 0, m_dummy = 0;
  bit m_a4 = 0;
  logic [31:0] m_base = 0;
  int fl_n = 0, sck_rises = 0;
  logic [31:0] cap_op = 0, cap_addr = 0;
  logic [31:0] q[$];
  bit done = 0;

  function automatic int w_of(int c); return 1 << ((c == 3) ? 2 : c); endfunction
  function automatic logic [7:0] fn(logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'hA5;
  endfunction

  always @(posedge sck or posedge cs_n) begin
    if (cs_n) fl_n = 0;
    else begin
      int cb, ab, w;
      sck_rises++;
      cb = 8 / w_of(m_lc);
      ab = (m_a4 ? 32 : 24) / w_of(m_la);
      if (fl_n < cb) begin
        w = w_of(m_lc);
        cap_op = (cap_op << w) | (32'(io_out) & ((32'd1 << w) - 1));
      end else if (fl_n < cb + ab) begin
        w = w_of(m_la);
        cap_addr = (cap_addr << w) | (32'(io_out) & ((32'd1 << w) - 1));
      end
      fl_n++;
    end
  end

  always @(negedge sck or negedge cs_n) begin
    int w, pre, k, b;
    logic [7:0] by, bits;
    w = w_of(m_ld);
    pre = 8 / w_of(m_lc) + (m_a4 ? 32 : 24) / w_of(m_la) + m_dummy / w;
    if (!cs_n && fl_n >= pre) begin
      k = fl_n - pre;
      b = k * w;
      by = fn(m_base + 32'(b / 8));
      bits = (by >> (8 - w - (b % 8))) & 8'((1 << w) - 1);
      fl_io = (w == 1) ? {2'b0, bits[0], 1'b0} : bits[3:0];
    end
  end

  initial fl_io = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic cfg(int lc, int la, int ld, int dummy, bit a4, logic [7:0] op,
                     logic [7:0] up, bit commit);
    wr(0, (32'(lc) << 24) | (32'(la) << 16) | 32'(ld));
    wr(1, (32'(a4) << 16) | 32'(dummy));
    wr(2, 32'(op));
    wr(3, {up, 24'h0});
    if (commit) begin
      wr(11, 1);
      m_lc = lc; m_la = la; m_ld = ld; m_dummy = dummy; m_a4 = a4;
    end
  endtask

  task automatic start(logic [7:0] up, logic [23:0] lo, int count, int nexp);
    logic [31:0] a;
    m_base = m_a4 ? {up, lo} : {8'h0, lo};
    for (int i = 0; i < nexp; i++) begin
      a = m_base + 32'(4 * i);
      q.push_back({fn(a + 3), fn(a + 2), fn(a + 1), fn(a)});
    end
    wr(4, {8'h0, lo});
    wr(5, 32'(count));
    wr(6, 1);
  endtask

  task automatic drain(string tag);
    logic [31:0] st, d;
    int guard = 0;
    forever begin
      rd(7, st);
      if (!st[1]) begin
        rd(8, d);
        if (q.size() == 0) check({tag, " extra word"}, d, 32'hx);
        else check({tag, " word"}, d, q.pop_front());
      end else if (!st[0]) break;
      guard++;
      if (guard > 20000) begin check({tag, " drain timeout"}, 0, 1); break; end
    end
    check({tag, " words outstanding"}, 32'(q.size()), 0);
    q.delete();
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int r0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(7, v); check("R1 status", v, 2);
    check("R1 cs_n", 32'(cs_n), 1);
    check("R1 sck", 32'(sck), 0);
    rd(9, v); check("R1 word count", v, 0);

    // R2 R3 single lane, 3-byte, 8 dummy bits
    cfg(0, 0, 0, 8, 0, 8'h0B, 8'h00, 1);
    start(8'h00, 24'h000100, 3, 3);
    drain("R2 R3 single");
    check("R2 opcode single", cap_op & 32'hFF, 32'h0B);
    check("R4 addr 3-byte", cap_addr & 32'hFFFFFF, 32'h000100);
    rd(9, v); check("R11 word count", v, 3);
    rd(10, v); check("R11 current addr", v, 32'h0000010C);
    check("R10 cs_n after", 32'(cs_n), 1);

    // R2 R3 quad data, 8 dummy bits = 2 clocks
    cfg(0, 0, 2, 8, 0, 8'h6B, 8'h00, 1);
    start(8'h00, 24'h020000, 4, 4);
    drain("R2 R3 quad data");
    check("R2 opcode quad data", cap_op & 32'hFF, 32'h6B);

    // R4 all-quad, 4-byte address, 24 dummy bits = 6 clocks
    cfg(2, 2, 2, 24, 1, 8'hEC, 8'h12, 1);
    start(8'h12, 24'h345678, 2, 2);
    drain("R4 quad 4-byte");
    check("R4 addr 4-byte", cap_addr, 32'h12345678);
    check("R2 opcode quad cmd", cap_op & 32'hFF, 32'hEC);
    rd(10, v); check("R11 current addr 4-byte", v, 32'h12345680);

    // R2 dual, no dummy
    cfg(0, 1, 1, 0, 0, 8'hBB, 8'h00, 1);
    start(8'h00, 24'h0ABCD0, 2, 2);
    drain("R2 dual");
    check("R4 addr dual", cap_addr & 32'hFFFFFF, 32'h0ABCD0);

    // R5 uncommitted shape is not used
    cfg(0, 0, 2, 8, 1, 8'h3B, 8'h77, 0);
    start(8'h00, 24'h000200, 1, 1);
    drain("R5 uncommitted");
    check("R5 old opcode kept", cap_op & 32'hFF, 32'hBB);
    check("R5 old addr size kept", cap_addr & 32'hFFFFFF, 32'h000200);

    // R8 window edge
    cfg(0, 0, 2, 8, 1, 8'hEB, 8'h12, 1);
    start(8'h12, 24'hFFFFF8, 5, 2);
    drain("R8 window");
    rd(9, v); check("R8 words at window edge", v, 2);
    rd(10, v); check("R8 address wrap", v, 32'h12000000);
    rd(7, v); check("R10 idle after window", v, 2);

    // R9 stall, R6 start ignored while busy
    start(8'h12, 24'h000040, 7, 7);
    repeat (400) @(negedge clk);
    rd(7, v); check("R9 busy while stalled", v & 1, 1);
    rd(9, v); check("R9 words at full", v, 4);
    r0 = sck_rises;
    repeat (100) @(negedge clk);
    check("R9 sck parked", 32'(sck_rises), 32'(r0));
    check("R9 cs_n held", 32'(cs_n), 0);
    wr(5, 2); wr(6, 1);
    drain("R9 R6 resume");
    rd(9, v); check("R6 no restart while busy", v, 7);

    // R6 count zero
    wr(5, 0); wr(6, 1);
    repeat (20) @(negedge clk);
    rd(7, v); check("R6 zero count idle", v, 2);
    check("R6 zero count cs_n", 32'(cs_n), 1);

    // R7 pop when empty
    rd(8, v); check("R7 empty pop value", v, 0);
    rd(7, v); check("R7 empty after pop", v, 2);

    done = 1;
    summary();
    $finish;
  end
endmodule